// File: doc/BRIEF.md
# Receive MAC control-frame statistics counters

This block keeps two receive-side statistics counters for an Ethernet MAC. The receive path hands it one status strobe per finished frame. The strobe carries five things: the frame length, whether the CRC checked good, whether the frame carried a VLAN tag, whether it was a MAC control frame, and the 16-bit control opcode. The receive path sets the control-frame flag for EtherType 0x8808. The first counter counts every MAC control frame that passes qualification, whatever its opcode. The second counts only PAUSE frames, which carry opcode 0x0001.

A frame qualifies when its CRC is good and its length lies inside a window. The window starts at 64 bytes. Its top is 1518 bytes for untagged frames and 1522 bytes for tagged frames. Both counters are 16 bits wide and sit in the low half of a 32-bit register word. Software reads and writes them through a small register port. A write to a counter wins over an increment in the same cycle. Each counter also raises a one-cycle carry pulse when it rolls over from 0xFFFF to 0x0000.

Top module: `rx_ctl_stat_counters`

## Requirements
- R1: A status strobe that qualifies and has the control flag set raises the control counter by exactly one, for any opcode value.
- R2: A status strobe that qualifies, has the control flag set and has opcode 0x0001 also raises the pause counter by exactly one. Any other opcode leaves the pause counter unchanged.
- R3: A strobe with the control flag clear changes neither counter, even when its opcode field holds 0x0001.
- R4: A strobe whose CRC-valid flag is low changes neither counter.
- R5: For an untagged frame (VLAN flag low), only lengths from 64 to 1518 inclusive count.
- R6: For a tagged frame (VLAN flag high), only lengths from 64 to 1522 inclusive count.
- R7: Register address 0 selects the control counter and address 1 selects the pause counter. A read returns the counter in bits [15:0], with bits [31:16] always zero. A write stores bits [15:0] of the write data, and the new value is visible on the read port after the next rising clock edge.
- R8: After reset both counters read as zero and both carry pulses are low.
- R9: When a write to a counter and a qualifying increment of that same counter land in the same cycle, the counter takes the written value. The other counter still increments normally.
- R10: An increment from 0xFFFF leaves the counter at 0x0000. It also raises that counter's carry output for exactly one cycle, the cycle right after the updating edge. Writing a value never raises a carry.
- R11: While the strobe-valid input is low, the length, flag and opcode inputs have no effect on either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | One-cycle end-of-frame status strobe |
| st_len | input | 14 | Frame length in bytes |
| st_crc_ok | input | 1 | CRC checked good |
| st_vlan | input | 1 | Frame carries a VLAN tag |
| st_ctl | input | 1 | Frame is a MAC control frame (EtherType 0x8808) |
| st_opcode | input | 16 | Control opcode |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 1 | Register word select: 0 control, 1 pause |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| ctl_wrap | output | 1 | Control counter rollover pulse |
| pause_wrap | output | 1 | Pause counter rollover pulse |

## Verification
A status strobe or a write shows up on the read port one clock edge after it is driven. The read data is a purely combinational function of the address. The bench therefore drives each stimulus on a falling edge and drops it on the next falling edge. It then selects each counter address and samples one time unit later. A carry pulse is due in the cycle that follows the edge on which the counter wrapped, so the bench samples it at the first falling edge after that edge. It samples again one cycle later to confirm the pulse has cleared. The main sweep covers every length near both window edges, crossed with the CRC, tag and control flags and four opcode values. The expected counts come from a bench-side qualification formula.

// File: rtl/rxcs_pkg.sv
package rxcs_pkg;

   // Which counter a register word selects.
   typedef enum logic {
      RXCS_SEL_CTL   = 1'b0,
      RXCS_SEL_PAUSE = 1'b1
   } rxcs_sel_e;

   // Number of counters held by the block.
   localparam int unsigned RXCS_NUM_CNT = 2;

   // Per-frame qualification result.
   typedef struct packed {
      logic hit_pause;
      logic hit_ctl;
   } rxcs_hits_t;

   // Inclusive window test on a frame length.
   function automatic logic rxcs_in_window(input int unsigned len,
                                           input int unsigned lo,
                                           input int unsigned hi);
      return (len >= lo) && (len <= hi);
   endfunction

endpackage

// File: rtl/rxcs_qualify.sv
module rxcs_qualify
   import rxcs_pkg::*;
#(
   parameter int unsigned LEN_W      = 14,
   parameter int unsigned OPC_W      = 16,
   parameter int unsigned MIN_LEN    = 64,
   parameter int unsigned MAX_PLAIN  = 1518,
   parameter int unsigned MAX_TAGGED = 1522,
   parameter logic [OPC_W-1:0] PAUSE_OPC = 16'h0001
) (
   input  logic             st_valid,
   input  logic [LEN_W-1:0] st_len,
   input  logic             st_crc_ok,
   input  logic             st_vlan,
   input  logic             st_ctl,
   input  logic [OPC_W-1:0] st_opcode,
   output rxcs_hits_t       hits
);

   localparam int unsigned LEN_LIMIT = (1 << LEN_W) - 1;

   // Elaboration-time parameter checks.
   if (MAX_TAGGED < MAX_PLAIN) begin : g_bad_window
      $error("rxcs_qualify: tagged limit below untagged limit");
   end
   if (MAX_TAGGED > LEN_LIMIT) begin : g_bad_len_w
      $error("rxcs_qualify: LEN_W too narrow for length window");
   end
   if (MIN_LEN > MAX_PLAIN) begin : g_bad_min
      $error("rxcs_qualify: minimum length above maximum");
   end

   logic        len_ok;
   logic        frame_ok;
   logic        is_pause;
   int unsigned len_u;
   int unsigned top_u;

   always_comb begin
      len_u    = int'(st_len);
      top_u    = st_vlan ? MAX_TAGGED : MAX_PLAIN;
      len_ok   = rxcs_in_window(len_u, MIN_LEN, top_u);
      frame_ok = st_valid && st_crc_ok && st_ctl && len_ok;
      is_pause = (st_opcode == PAUSE_OPC);
      hits.hit_ctl   = frame_ok;
      hits.hit_pause = frame_ok && is_pause;
   end

endmodule

// File: rtl/rxcs_counter.sv
module rxcs_counter #(
   parameter int unsigned CNT_W      = 16,
   parameter bit          WRAP_PULSE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);

   if (CNT_W < 2) begin : g_bad_width
      $error("rxcs_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic             bump;
   logic [CNT_W-1:0] next_count;

   assign bump       = inc && !wr_en;
   assign next_count = count + {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (wr_en) begin
         count <= wr_data;
      end else if (inc) begin
         count <= next_count;
      end
   end

   if (WRAP_PULSE) begin : g_wrap
      logic wrap_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wrap_q <= 1'b0;
         end else begin
            wrap_q <= bump && (count == ALL_ONES);
         end
      end
      assign wrap = wrap_q;
   end else begin : g_no_wrap
      assign wrap = 1'b0;
   end

endmodule

// File: rtl/rxcs_regport.sv
module rxcs_regport
   import rxcs_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned REG_W  = 32,
   parameter int unsigned ADDR_W = 1
) (
   input  logic                                reg_wr,
   input  logic [ADDR_W-1:0]                   reg_addr,
   input  logic [REG_W-1:0]                    reg_wdata,
   input  logic [RXCS_NUM_CNT-1:0][CNT_W-1:0]  counts,
   output logic [RXCS_NUM_CNT-1:0]             wr_sel,
   output logic [CNT_W-1:0]                    wr_data,
   output logic [REG_W-1:0]                    reg_rdata
);

   if (REG_W < CNT_W) begin : g_bad_reg_w
      $error("rxcs_regport: register narrower than counter");
   end
   if ((1 << ADDR_W) < RXCS_NUM_CNT) begin : g_bad_addr_w
      $error("rxcs_regport: ADDR_W cannot reach every counter");
   end

   localparam int unsigned PAD_W = REG_W - CNT_W;

   assign wr_data = reg_wdata[CNT_W-1:0];

   for (genvar i = 0; i < RXCS_NUM_CNT; i++) begin : g_sel
      assign wr_sel[i] = reg_wr && (reg_addr == ADDR_W'(i));
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < RXCS_NUM_CNT; i++) begin
         if (reg_addr == ADDR_W'(i)) begin
            reg_rdata = {{PAD_W{1'b0}}, counts[i]};
         end
      end
   end

endmodule

// File: rtl/rx_ctl_stat_counters.sv
module rx_ctl_stat_counters
   import rxcs_pkg::*;
#(
   parameter int unsigned LEN_W      = 14,
   parameter int unsigned OPC_W      = 16,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned REG_W      = 32,
   parameter int unsigned ADDR_W     = 1,
   parameter int unsigned MIN_LEN    = 64,
   parameter int unsigned MAX_PLAIN  = 1518,
   parameter int unsigned MAX_TAGGED = 1522,
   parameter logic [OPC_W-1:0] PAUSE_OPC = 16'h0001,
   parameter bit          WRAP_PULSE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [LEN_W-1:0]  st_len,
   input  logic              st_crc_ok,
   input  logic              st_vlan,
   input  logic              st_ctl,
   input  logic [OPC_W-1:0]  st_opcode,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              ctl_wrap,
   output logic              pause_wrap
);

   rxcs_hits_t                         hits;
   logic [RXCS_NUM_CNT-1:0]            inc_vec;
   logic [RXCS_NUM_CNT-1:0]            wr_sel;
   logic [CNT_W-1:0]                   wr_data;
   logic [RXCS_NUM_CNT-1:0][CNT_W-1:0] counts;
   logic [RXCS_NUM_CNT-1:0]            wraps;
   logic [CNT_W-1:0]                   ctl_cnt;
   logic [CNT_W-1:0]                   pause_cnt;

   rxcs_qualify #(
      .LEN_W      (LEN_W),
      .OPC_W      (OPC_W),
      .MIN_LEN    (MIN_LEN),
      .MAX_PLAIN  (MAX_PLAIN),
      .MAX_TAGGED (MAX_TAGGED),
      .PAUSE_OPC  (PAUSE_OPC)
   ) u_qual (
      .st_valid  (st_valid),
      .st_len    (st_len),
      .st_crc_ok (st_crc_ok),
      .st_vlan   (st_vlan),
      .st_ctl    (st_ctl),
      .st_opcode (st_opcode),
      .hits      (hits)
   );

   assign inc_vec[RXCS_SEL_CTL]   = hits.hit_ctl;
   assign inc_vec[RXCS_SEL_PAUSE] = hits.hit_pause;

   rxcs_regport #(
      .CNT_W  (CNT_W),
      .REG_W  (REG_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .counts    (counts),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .reg_rdata (reg_rdata)
   );

   for (genvar i = 0; i < RXCS_NUM_CNT; i++) begin : g_cnt
      rxcs_counter #(
         .CNT_W      (CNT_W),
         .WRAP_PULSE (WRAP_PULSE)
      ) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc     (inc_vec[i]),
         .wr_en   (wr_sel[i]),
         .wr_data (wr_data),
         .count   (counts[i]),
         .wrap    (wraps[i])
      );
   end

   assign ctl_cnt    = counts[RXCS_SEL_CTL];
   assign pause_cnt  = counts[RXCS_SEL_PAUSE];
   assign ctl_wrap   = wraps[RXCS_SEL_CTL];
   assign pause_wrap = wraps[RXCS_SEL_PAUSE];

endmodule

// File: rtl/rxcs_checker.sv
module rxcs_checker #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned REG_W  = 32,
   parameter int unsigned ADDR_W = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              st_valid,
   input logic              st_crc_ok,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [REG_W-1:0]  reg_wdata,
   input logic [REG_W-1:0]  reg_rdata,
   input logic [CNT_W-1:0]  ctl_cnt,
   input logic [CNT_W-1:0]  pause_cnt,
   input logic              ctl_wrap,
   input logic              pause_wrap
);

   // R7: upper half of every register word reads as zero
   assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[REG_W-1:CNT_W] == '0);

   // R4: bad CRC leaves both counters alone
   assert_bad_crc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_crc_ok && !reg_wr) |=>
         (ctl_cnt == $past(ctl_cnt) && pause_cnt == $past(pause_cnt)));

   // R11: no strobe and no write leaves both counters alone
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_valid && !reg_wr) |=> ($stable(ctl_cnt) && $stable(pause_cnt)));

   // R1: without a write the control counter moves by at most one
   assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !reg_wr) |=>
         (ctl_cnt == $past(ctl_cnt) || ctl_cnt == $past(ctl_cnt) + 1'b1));

   // R2: a pause count always comes with a control count
   assert_pause_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!reg_wr) && pause_cnt != $past(pause_cnt)) |-> (ctl_cnt != $past(ctl_cnt)));

   // R9: a write to the control word sets its value
   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(0)) |=> (ctl_cnt == $past(reg_wdata[CNT_W-1:0])));

   // R10: a carry pulse coincides with a zero count and lasts one cycle
   assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wrap |-> (ctl_cnt == '0));
   assert_wrap_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pause_wrap |=> !pause_wrap);

endmodule

bind rx_ctl_stat_counters rxcs_checker #(
   .CNT_W  (CNT_W),
   .REG_W  (REG_W),
   .ADDR_W (ADDR_W)
) u_rxcs_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .st_valid   (st_valid),
   .st_crc_ok  (st_crc_ok),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .ctl_cnt    (ctl_cnt),
   .pause_cnt  (pause_cnt),
   .ctl_wrap   (ctl_wrap),
   .pause_wrap (pause_wrap)
);

// File: tb/rx_ctl_stat_counters_test.sv
module rx_ctl_stat_counters_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_valid = 1'b0;
   logic [13:0] st_len = '0;
   logic        st_crc_ok = 1'b0;
   logic        st_vlan = 1'b0;
   logic        st_ctl = 1'b0;
   logic [15:0] st_opcode = '0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ctl_wrap;
   logic        pause_wrap;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int exp_ctl = 0;
   int exp_pause = 0;

   int lens [13] = '{0, 63, 64, 65, 1000, 1517, 1518, 1519, 1520, 1521, 1522, 1523, 16383};
   logic [15:0] opcs [4] = '{16'h0001, 16'h0000, 16'h0002, 16'hFFFF};

   always #2 clk = ~clk;

   rx_ctl_stat_counters uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_valid   (st_valid),
      .st_len     (st_len),
      .st_crc_ok  (st_crc_ok),
      .st_vlan    (st_vlan),
      .st_ctl     (st_ctl),
      .st_opcode  (st_opcode),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .ctl_wrap   (ctl_wrap),
      .pause_wrap (pause_wrap)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic check_counts(input string req);
      logic [31:0] v;
      rd(1'b0, v);
      check(req, v, 32'(exp_ctl & 16'hFFFF));
      rd(1'b1, v);
      check(req, v, 32'(exp_pause & 16'hFFFF));
   endtask

   task automatic frame(input int len, input logic crc, input logic vlan,
                        input logic ctl, input logic [15:0] opc);
      @(negedge clk);
      st_len = 14'(len); st_crc_ok = crc; st_vlan = vlan;
      st_ctl = ctl; st_opcode = opc; st_valid = 1'b1;
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   function automatic bit qualifies(input int len, input logic crc, input logic vlan);
      int top;
      top = vlan ? 1522 : 1518;
      return crc && (len >= 64) && (len <= top);
   endfunction

   initial begin
      logic [31:0] v;
      string tag;
      repeat (3) @(negedge clk);
      // R8: reset state
      check_counts("R8");
      check("R8 ctl_wrap", 32'(ctl_wrap), 32'h0);
      check("R8 pause_wrap", 32'(pause_wrap), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check_counts("R8");

      // Sweep: R1 R2 R3 R4 R5 R6
      for (int li = 0; li < 13; li++) begin
         for (int f = 0; f < 8; f++) begin
            for (int oi = 0; oi < 4; oi++) begin
               logic crc, vl, ct;
               crc = f[0]; vl = f[1]; ct = f[2];
               frame(lens[li], crc, vl, ct, opcs[oi]);
               if (ct && qualifies(lens[li], crc, vl)) begin
                  exp_ctl++;
                  if (opcs[oi] == 16'h0001) exp_pause++;
               end
               if (!ct) tag = "R3";
               else if (!crc) tag = "R4";
               else if (vl) tag = "R6";
               else if (opcs[oi] == 16'h0001) tag = "R2";
               else tag = "R5";
               check_counts(tag);
            end
         end
      end

      // R11: qualifying fields with strobe low
      @(negedge clk);
      st_len = 14'd100; st_crc_ok = 1'b1; st_vlan = 1'b0;
      st_ctl = 1'b1; st_opcode = 16'h0001; st_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_counts("R11");

      // R7: write, reserved bits, address map
      wr(1'b0, 32'hABCD_5678);
      wr(1'b1, 32'h1234_9ABC);
      rd(1'b0, v); check("R7 ctl word", v, 32'h0000_5678);
      rd(1'b1, v); check("R7 pause word", v, 32'h0000_9ABC);
      exp_ctl = 16'h5678; exp_pause = 16'h9ABC;

      // R9: write to pause word with qualifying pause frame in same cycle
      @(negedge clk);
      st_len = 14'd64; st_crc_ok = 1'b1; st_vlan = 1'b1; st_ctl = 1'b1;
      st_opcode = 16'h0001; st_valid = 1'b1;
      reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h0000_0042;
      @(negedge clk);
      st_valid = 1'b0; reg_wr = 1'b0;
      exp_ctl++; exp_pause = 16'h0042;
      check_counts("R9");

      // R10: wrap both counters, no carry from writes
      wr(1'b0, 32'h0000_FFFF);
      check("R10 no carry on write", 32'(ctl_wrap), 32'h0);
      wr(1'b1, 32'h0000_FFFF);
      check("R10 no carry on write", 32'(pause_wrap), 32'h0);
      frame(1522, 1'b1, 1'b1, 1'b1, 16'h0001);
      check("R10 ctl carry", 32'(ctl_wrap), 32'h1);
      check("R10 pause carry", 32'(pause_wrap), 32'h1);
      exp_ctl = 0; exp_pause = 0;
      check_counts("R10");
      @(negedge clk);
      check("R10 ctl carry clear", 32'(ctl_wrap), 32'h0);
      check("R10 pause carry clear", 32'(pause_wrap), 32'h0);

      // R10: only the control counter wraps on a non-pause opcode
      wr(1'b0, 32'h0000_FFFF);
      frame(1518, 1'b1, 1'b0, 1'b1, 16'h0101);
      check("R10 ctl carry only", 32'(ctl_wrap), 32'h1);
      check("R10 pause quiet", 32'(pause_wrap), 32'h0);
      exp_ctl = 0;
      check_counts("R10");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule